// File: doc/BRIEF.md
# Bisecting Phase Estimator for Fringe Profiles

This block takes one detrended intensity profile, streamed as signed samples together with its half peak-to-peak amplitude, and returns the index of the phase step that best fits a sinusoid of known frequency. The phase range from -pi to +pi is split into a power-of-two number of equal steps. The estimator does not evaluate an arctangent. It correlates the profile against sine and cosine tables indexed by pixel position. It then bisects the step range, looking for the sign change of the derivative of a least-squares cost. Each value of that derivative is built from three per-step tables: sin(theta), cos(theta), and the amplitude term cos(2theta)*S4 + sin(2theta)*C4. S4 and C4 are the profile sums of sin(4*pi*f*i) and cos(4*pi*f*i).

All tables are written through a single write port before acquisition starts. Every calculation uses integers. Trigonometric entries carry FRAC fractional bits. The derivative at step b is 2*(Is*cos[b] + Ic*sin[b]) - (amp*Aterm[b] << FRAC). The block reports the chosen step index and a signed phase code, and marks the result with a single-cycle done strobe. It then accepts the next profile.

Top module: `phs_search`

## Requirements
- R1: While rst_n is low and after its release, done and busy are 0 and step_idx is 0.
- R2: For each profile the block forms Is = sum of sample[i]*possin[i] and Ic = sum of sample[i]*poscos[i], with i counting from 0 at the first sample after a profile ends. The sample carrying smp_last closes the profile and latches smp_amp.
- R3: The search begins with left index 0 and left value -(2*Is << FRAC) - (amp*Aterm[0] << FRAC), step NSTEP/2, and right index equal to the step.
- R4: There are exactly STEP_LOG2 probes. At each probe the right value is evaluated at the right index. If the pair is not (left < 0 and right >= 0), the left index and left value move to the right probe. The step then halves and the right index becomes left + step.
- R5: After the last probe the value at (left+1) mod NSTEP is evaluated. The result is the left index when |left value| < that value, and otherwise (left+1) mod NSTEP. For example, a profile with every value zero yields step 0.
- R6: done is high for exactly one cycle. It rises STEP_LOG2+2 rising edges after the edge that accepts the closing sample.
- R7: busy is high from the edge that accepts the closing sample until the edge that raises done. Samples offered while busy is high are ignored and do not affect the current or the next result.
- R8: phase_code equals step_idx - NSTEP/2 in two's complement, so the phase is phase_code*2*pi/NSTEP.
- R9: A table write stores tbl_data at tbl_addr in the table chosen by tbl_sel. The codes are 0 = per-position sine, 1 = per-position cosine, 2 = per-step sine, 3 = per-step cosine, 4 = per-step amplitude term. Per-position tables use the low POS_LOG2 address bits. Trig tables use the low TRIG_W data bits.
- R10: step_idx and phase_code hold their values between done strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_sel | input | 3 | Table select code |
| tbl_addr | input | STEP_LOG2 | Table write address |
| tbl_data | input | AMPT_W | Table write data (signed) |
| smp_valid | input | 1 | Sample present |
| smp_data | input | SMP_W | Detrended sample (signed) |
| smp_last | input | 1 | Sample closes the profile |
| smp_amp | input | SMP_W | Profile amplitude, taken with the closing sample |
| busy | output | 1 | Search in progress, samples ignored |
| done | output | 1 | One-cycle result strobe |
| step_idx | output | STEP_LOG2 | Selected phase step |
| phase_code | output | STEP_LOG2 | Signed phase in units of 2*pi/NSTEP |

## Verification
The bench compares each result with an integer model of the bisection applied to cosine profiles with random phase and noise. A design that reversed the move rule, or that dropped the literal starting value, would settle on a different step. An all-zero profile forces the left index to march to the top step, so that the final comparison has to wrap to step 0; a design without the modulo would report an index one past the range or pick the wrong side. Junk samples, some of them marked as closing a profile, are offered while a search runs. An engine that took them would corrupt its accumulators or position counter, and the next result would then differ from the model.

// File: rtl/phs_pkg.sv
package phs_pkg;
  localparam int SMP_W     = 14;
  localparam int TRIG_W    = 16;
  localparam int AMPT_W    = 24;
  localparam int FRAC      = 14;
  localparam int STEP_LOG2 = 10;
  localparam int POS_LOG2  = 5;
  localparam int NSTEP     = 1 << STEP_LOG2;
  localparam int NPOS      = 1 << POS_LOG2;
  localparam int CORR_W    = SMP_W + TRIG_W + POS_LOG2;
  localparam int VAL_W     = CORR_W + TRIG_W + 3;

  localparam logic [2:0] SEL_POS_SIN  = 3'd0;
  localparam logic [2:0] SEL_POS_COS  = 3'd1;
  localparam logic [2:0] SEL_STEP_SIN = 3'd2;
  localparam logic [2:0] SEL_STEP_COS = 3'd3;
  localparam logic [2:0] SEL_STEP_AMP = 3'd4;

  typedef logic signed [SMP_W-1:0]  smp_t;
  typedef logic signed [TRIG_W-1:0] trig_t;
  typedef logic signed [AMPT_W-1:0] ampt_t;
  typedef logic signed [CORR_W-1:0] corr_t;
  typedef logic signed [VAL_W-1:0]  val_t;
  typedef logic [STEP_LOG2-1:0]     step_t;
  typedef logic [POS_LOG2-1:0]      pos_t;

  // derivative of the cost at one probe step
  function automatic val_t probe_value(corr_t s_corr, corr_t c_corr,
                                       trig_t cos_b, trig_t sin_b,
                                       smp_t amp, ampt_t aterm);
    val_t t_s, t_c, t_a;
    t_s = val_t'(s_corr) * val_t'(cos_b);
    t_c = val_t'(c_corr) * val_t'(sin_b);
    t_a = (val_t'(amp) * val_t'(aterm)) <<< FRAC;
    return ((t_s + t_c) <<< 1) - t_a;
  endfunction

  // starting left value, cos(-pi) = -1 and sin(-pi) = 0 taken literally
  function automatic val_t init_value(corr_t s_corr, smp_t amp, ampt_t aterm0);
    val_t t_s, t_a;
    t_s = val_t'(s_corr) <<< (FRAC + 1);
    t_a = (val_t'(amp) * val_t'(aterm0)) <<< FRAC;
    return -t_s - t_a;
  endfunction

  function automatic corr_t mac_term(smp_t smp, trig_t coef);
    return corr_t'(smp) * corr_t'(coef);
  endfunction
endpackage

// File: rtl/phs_tables.sv
module phs_tables
  import phs_pkg::*;
(
  input  logic       clk,
  input  logic       we,
  input  logic [2:0] sel,
  input  step_t      waddr,
  input  ampt_t      wdata,
  input  pos_t       pos_ra,
  input  step_t      step_ra,
  output trig_t      pos_sin,
  output trig_t      pos_cos,
  output trig_t      step_sin,
  output trig_t      step_cos,
  output ampt_t      step_amp
);
  trig_t m_pos_sin  [NPOS];
  trig_t m_pos_cos  [NPOS];
  trig_t m_step_sin [NSTEP];
  trig_t m_step_cos [NSTEP];
  ampt_t m_step_amp [NSTEP];

  trig_t wtrig;
  pos_t  wpos;
  assign wtrig = wdata[TRIG_W-1:0];
  assign wpos  = waddr[POS_LOG2-1:0];

  always_ff @(posedge clk) begin
    if (we) begin
      case (sel)
        SEL_POS_SIN:  m_pos_sin[wpos]   <= wtrig;
        SEL_POS_COS:  m_pos_cos[wpos]   <= wtrig;
        SEL_STEP_SIN: m_step_sin[waddr] <= wtrig;
        SEL_STEP_COS: m_step_cos[waddr] <= wtrig;
        SEL_STEP_AMP: m_step_amp[waddr] <= wdata;
        default: ;
      endcase
    end
  end

  assign pos_sin  = m_pos_sin[pos_ra];
  assign pos_cos  = m_pos_cos[pos_ra];
  assign step_sin = m_step_sin[step_ra];
  assign step_cos = m_step_cos[step_ra];
  assign step_amp = m_step_amp[step_ra];
endmodule

// File: rtl/phs_correlator.sv
module phs_correlator
  import phs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  accept,
  input  smp_t  smp,
  input  logic  last,
  input  smp_t  amp_in,
  input  trig_t pos_sin,
  input  trig_t pos_cos,
  output pos_t  pos,
  output corr_t s_corr,
  output corr_t c_corr,
  output smp_t  amp_q,
  output logic  start
);
  logic  fresh;
  corr_t s_base, c_base;

  assign fresh  = (pos == '0);
  assign s_base = fresh ? '0 : s_corr;
  assign c_base = fresh ? '0 : c_corr;
  assign start  = accept && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos    <= '0;
      s_corr <= '0;
      c_corr <= '0;
      amp_q  <= '0;
    end else if (accept) begin
      s_corr <= s_base + mac_term(smp, pos_sin);
      c_corr <= c_base + mac_term(smp, pos_cos);
      pos    <= last ? '0 : pos + pos_t'(1);
      if (last) amp_q <= amp_in;
    end
  end
endmodule

// File: rtl/phs_bisect.sv
module phs_bisect
  import phs_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  corr_t s_corr,
  input  corr_t c_corr,
  input  smp_t  amp,
  input  trig_t step_sin,
  input  trig_t step_cos,
  input  ampt_t step_amp,
  output step_t probe_idx,
  output logic  busy,
  output logic  done,
  output step_t result,
  output logic  probe_fire,
  output logic  final_fire
);
  typedef enum logic [1:0] {S_IDLE, S_INIT, S_PROBE, S_FINAL} st_e;

  st_e   st;
  step_t delta, left_idx, right_idx, next_idx;
  val_t  left_val, v_probe, v_init, left_abs;
  logic  crossing, move_left, keep_left;

  assign right_idx  = left_idx + delta;
  assign next_idx   = left_idx + step_t'(1);
  assign v_probe    = probe_value(s_corr, c_corr, step_cos, step_sin, amp, step_amp);
  assign v_init     = init_value(s_corr, amp, step_amp);
  assign probe_fire = (st == S_PROBE);
  assign final_fire = (st == S_FINAL);
  assign busy       = (st != S_IDLE);
  assign crossing   = left_val[VAL_W-1] && !v_probe[VAL_W-1];
  assign move_left  = probe_fire && !crossing;
  assign left_abs   = left_val[VAL_W-1] ? -left_val : left_val;
  assign keep_left  = left_abs < v_probe;

  always_comb begin
    case (st)
      S_PROBE: probe_idx = right_idx;
      S_FINAL: probe_idx = next_idx;
      default: probe_idx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      delta    <= '0;
      left_idx <= '0;
      left_val <= '0;
      result   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) st <= S_INIT;
        S_INIT: begin
          left_val <= v_init;
          left_idx <= '0;
          delta    <= step_t'(NSTEP / 2);
          st       <= S_PROBE;
        end
        S_PROBE: begin
          if (move_left) begin
            left_idx <= right_idx;
            left_val <= v_probe;
          end
          delta <= delta >> 1;
          if (delta == step_t'(1)) st <= S_FINAL;
        end
        S_FINAL: begin
          result <= keep_left ? left_idx : next_idx;
          done   <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phs_search.sv
module phs_search
  import phs_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tbl_we,
  input  logic [2:0]                  tbl_sel,
  input  logic [STEP_LOG2-1:0]        tbl_addr,
  input  logic signed [AMPT_W-1:0]    tbl_data,
  input  logic                        smp_valid,
  input  logic signed [SMP_W-1:0]     smp_data,
  input  logic                        smp_last,
  input  logic signed [SMP_W-1:0]     smp_amp,
  output logic                        busy,
  output logic                        done,
  output logic [STEP_LOG2-1:0]        step_idx,
  output logic signed [STEP_LOG2-1:0] phase_code
);
  logic  accept, start, probe_fire, final_fire;
  pos_t  pos;
  step_t probe_idx, result;
  corr_t s_corr, c_corr;
  smp_t  amp_q;
  trig_t pos_sin, pos_cos, step_sin, step_cos;
  ampt_t step_amp;

  assign accept = smp_valid && !busy;

  phs_tables u_tables (
    .clk(clk), .we(tbl_we), .sel(tbl_sel), .waddr(tbl_addr), .wdata(tbl_data),
    .pos_ra(pos), .step_ra(probe_idx),
    .pos_sin(pos_sin), .pos_cos(pos_cos),
    .step_sin(step_sin), .step_cos(step_cos), .step_amp(step_amp)
  );

  phs_correlator u_corr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .smp(smp_data), .last(smp_last),
    .amp_in(smp_amp), .pos_sin(pos_sin), .pos_cos(pos_cos), .pos(pos),
    .s_corr(s_corr), .c_corr(c_corr), .amp_q(amp_q), .start(start)
  );

  phs_bisect u_bisect (
    .clk(clk), .rst_n(rst_n), .start(start), .s_corr(s_corr), .c_corr(c_corr),
    .amp(amp_q), .step_sin(step_sin), .step_cos(step_cos), .step_amp(step_amp),
    .probe_idx(probe_idx), .busy(busy), .done(done), .result(result),
    .probe_fire(probe_fire), .final_fire(final_fire)
  );

  assign step_idx   = result;
  assign phase_code = $signed({~result[STEP_LOG2-1], result[STEP_LOG2-2:0]});
endmodule

// File: rtl/phs_search_chk.sv
module phs_search_chk
  import phs_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  smp_valid,
  input logic  smp_last,
  input logic  busy,
  input logic  done,
  input step_t step_idx,
  input logic  probe_fire,
  input logic  final_fire
);
  logic [7:0] lat_cnt, prb_cnt;
  logic       start_ev;

  assign start_ev = smp_valid && smp_last && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= '0;
      prb_cnt <= '0;
    end else begin
      if (start_ev)            lat_cnt <= 8'd1;
      else if (done)           lat_cnt <= '0;
      else if (lat_cnt != '0)  lat_cnt <= lat_cnt + 8'd1;
      if (start_ev)            prb_cnt <= '0;
      else if (probe_fire)     prb_cnt <= prb_cnt + 8'd1;
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lat_cnt == 8'(STEP_LOG2 + 3));
  assert_probe_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    final_fire |-> prb_cnt == 8'(STEP_LOG2));
  assert_busy_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(smp_valid && smp_last));
  assert_idle_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(step_idx));
endmodule

bind phs_search phs_search_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_last(smp_last),
  .busy(busy), .done(done), .step_idx(step_idx),
  .probe_fire(probe_fire), .final_fire(final_fire)
);

// File: tb/sim_phs_search.sv
module sim_phs_search;
  import phs_pkg::*;

  localparam int  MLEN = 20;
  localparam real PI   = 3.14159265358979;
  localparam real FREQ = 0.19;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, tbl_we, smp_valid, smp_last, busy, done;
  logic [2:0] tbl_sel;
  logic [STEP_LOG2-1:0] tbl_addr, step_idx;
  logic signed [AMPT_W-1:0] tbl_data;
  logic signed [SMP_W-1:0] smp_data, smp_amp;
  logic signed [STEP_LOG2-1:0] phase_code;

  phs_search u0 (.*);

  int n_vec = 0, n_bad = 0, cyc = 0;
  longint t_psin[NPOS], t_pcos[NPOS];
  longint t_ssin[NSTEP], t_scos[NSTEP], t_samp[NSTEP];
  longint cur[NPOS];
  longint cur_amp;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  function automatic longint qround(real x);
    if (x >= 0.0) return longint'($rtoi(x + 0.5));
    return -longint'($rtoi(-x + 0.5));
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint deriv(longint si, longint ci, int b);
    return 2 * (si * t_scos[b] + ci * t_ssin[b]) - cur_amp * t_samp[b] * (longint'(1) << FRAC);
  endfunction

  // independent integer model of the bisection (R2..R5)
  function automatic int model_step();
    longint si = 0, ci = 0, vl, vr;
    int bl = 0, dl = NSTEP / 2, bn;
    for (int i = 0; i < MLEN; i++) begin
      si += cur[i] * t_psin[i];
      ci += cur[i] * t_pcos[i];
    end
    vl = -2 * si * (longint'(1) << FRAC) - cur_amp * t_samp[0] * (longint'(1) << FRAC);
    while (dl >= 1) begin
      vr = deriv(si, ci, bl + dl);
      if (!(vl < 0 && vr >= 0)) begin
        vl = vr;
        bl = bl + dl;
      end
      dl = dl / 2;
    end
    bn = (bl + 1) % NSTEP;
    vr = deriv(si, ci, bn);
    if (((vl < 0) ? -vl : vl) < vr) return bl;
    return bn;
  endfunction

  task automatic wr_tbl(input logic [2:0] sel, input int addr, input longint data);
    @(negedge clk);
    tbl_we   = 1'b1;
    tbl_sel  = sel;
    tbl_addr = STEP_LOG2'(addr);
    tbl_data = AMPT_W'(data);
  endtask

  task automatic load_tables();
    real s4 = 0.0, c4 = 0.0, th;
    for (int i = 0; i < MLEN; i++) begin
      s4 += $sin(4.0 * PI * FREQ * i);
      c4 += $cos(4.0 * PI * FREQ * i);
    end
    for (int i = 0; i < NPOS; i++) begin
      t_psin[i] = qround($sin(2.0 * PI * FREQ * i) * (1 << FRAC));
      t_pcos[i] = qround($cos(2.0 * PI * FREQ * i) * (1 << FRAC));
      wr_tbl(SEL_POS_SIN, i, t_psin[i]);
      wr_tbl(SEL_POS_COS, i, t_pcos[i]);
    end
    for (int k = 0; k < NSTEP; k++) begin
      th = -PI + 2.0 * PI * k / NSTEP;
      t_ssin[k] = qround($sin(th) * (1 << FRAC));
      t_scos[k] = qround($cos(th) * (1 << FRAC));
      t_samp[k] = qround(($cos(2.0 * th) * s4 + $sin(2.0 * th) * c4) * (1 << FRAC));
      wr_tbl(SEL_STEP_SIN, k, t_ssin[k]);
      wr_tbl(SEL_STEP_COS, k, t_scos[k]);
      wr_tbl(SEL_STEP_AMP, k, t_samp[k]);
    end
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic make_profile(input real theta, input real ampl, input int noise);
    longint mx = -100000, mn = 100000;
    for (int i = 0; i < NPOS; i++) cur[i] = 0;
    for (int i = 0; i < MLEN; i++) begin
      cur[i] = qround(ampl * $cos(2.0 * PI * FREQ * i + theta));
      if (noise > 0) cur[i] += longint'($urandom_range(2 * noise)) - noise;
      if (cur[i] > mx) mx = cur[i];
      if (cur[i] < mn) mn = cur[i];
    end
    cur_amp = (mx - mn) / 2;
  endtask

  task automatic run_profile(input bit junk, input int force_exp);
    int exp_idx, seen;
    exp_idx = (force_exp >= 0) ? force_exp : model_step();
    for (int i = 0; i < MLEN; i++) begin
      @(negedge clk);
      smp_valid = 1'b1;
      smp_data  = SMP_W'(cur[i]);
      smp_last  = (i == MLEN - 1);
      smp_amp   = SMP_W'(cur_amp);
    end
    seen = 0;
    for (int k = 1; k <= 20 && seen == 0; k++) begin
      @(negedge clk);
      if (junk && k <= 5) begin
        smp_valid = 1'b1;
        smp_data  = SMP_W'($urandom_range(4000));
        smp_last  = $urandom_range(1) == 1;
      end else begin
        smp_valid = 1'b0;
        smp_last  = 1'b0;
      end
      if (k == 2) check(busy == 1'b1, "R7 busy during search", longint'(busy), 1);
      if (done) seen = k;
    end
    smp_valid = 1'b0;
    smp_last  = 1'b0;
    check(seen == STEP_LOG2 + 3, "R6 done latency (negedge count)", seen, STEP_LOG2 + 3);
    check(int'(step_idx) == exp_idx, "R4 step index vs model", longint'(step_idx), exp_idx);
    check(int'(phase_code) == exp_idx - NSTEP / 2, "R8 phase code",
          longint'(phase_code), exp_idx - NSTEP / 2);
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", longint'(done), 0);
    check(int'(step_idx) == exp_idx, "R10 result held", longint'(step_idx), exp_idx);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; tbl_we = 1'b0; tbl_sel = '0; tbl_addr = '0; tbl_data = '0;
    smp_valid = 1'b0; smp_data = '0; smp_last = 1'b0; smp_amp = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && busy == 1'b0 && step_idx == '0, "R1 state in reset",
          longint'({done, busy, step_idx}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0 && step_idx == '0, "R1 state after reset",
          longint'({done, busy, step_idx}), 0);

    load_tables();  // R9 tables written through the port

    // R5: all-zero profile, left index climbs to the top, final wraps to 0
    make_profile(0.0, 0.0, 0);
    cur_amp = 0;
    run_profile(1'b0, 0);

    // directed edges near -pi and +pi, and quarter points (R3, R4)
    make_profile(-PI + 0.002, 2000.0, 0); run_profile(1'b0, -1);
    make_profile(PI - 0.002, 2000.0, 0);  run_profile(1'b0, -1);
    make_profile(PI / 2.0, 3000.0, 0);    run_profile(1'b0, -1);
    make_profile(-PI / 2.0, 1500.0, 0);   run_profile(1'b0, -1);

    // R7: junk offered during a search, then a clean profile (R2 restart)
    make_profile(0.7, 2500.0, 5);  run_profile(1'b1, -1);
    make_profile(-1.3, 2500.0, 5); run_profile(1'b0, -1);

    // random phases, amplitudes and noise
    for (int n = 0; n < 30; n++) begin
      real th, am;
      th = (real'($urandom_range(10000)) / 10000.0) * 2.0 * PI - PI;
      am = 300.0 + real'($urandom_range(3500));
      make_profile(th, am, int'($urandom_range(40)));
      run_profile(n % 3 == 0, -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule